// File: doc/BRIEF.md
# Table-Sequenced Serial Flash Engine

This block runs serial-flash transactions as short programs. Each program is built from up to eight instructions, held in a table that software writes. One 16-bit instruction tells the engine to do one of five things:

- send a command byte;
- send a 24- or 32-bit flash address;
- idle for a number of clocks;
- receive a number of bytes;
- send a number of bytes.

A sequence starts with one write to a trigger register. That write carries a sequence number and an optional byte count. The engine then drives chip select, a serial clock and a single data line in each direction until the program ends.

The table is protected. It can only be changed after a key write followed at once by an unlock command, and a keyed lock command protects it again. Received bytes are packed into a 128-byte buffer that is read as 32-bit words. Transmit data is pushed as 32-bit words into a 64-byte buffer. A status word reports the busy flag, the lock state and both fill levels in bytes.

Top module: `seqflash_engine`

## Requirements
- R1: After reset, chip select (`csN`) is high, `sck` is low and the status word at offset 0x18 reads 0x00000002. Its fields are: bit0 busy, bit1 locked, bits[15:8] receive fill in bytes, bits[22:16] transmit fill in bytes.
- R2: Table word i sits at offset 0x40+i. A write to it is ignored unless the table is unlocked. Unlocking takes a write of the key to offset 0x04 that is immediately followed by a write of 2 to offset 0x08. Writing the key and then 1 locks the table again. A lock-register write that does not directly follow the key write has no effect.
- R3: Sequence N uses table words 4N to 4N+3. In each word the low 16 bits run before the high 16 bits. An instruction is {opcode[15:10], pad[9:8], operand[7:0]}. The opcodes are 1 command, 2 address, 3 dummy, 4 read and 5 write.
- R4: A command sends its operand as 8 bits. An address sends the address register at offset 0x0C: the low 24 bits, or all 32 bits when the operand is 32. A dummy runs for operand clocks. Read and write move operand bytes. All bits go MSB first.
- R5: The trigger at offset 0x10 carries the sequence number in bits[10:8] and a byte count in bits[7:0]. A nonzero count replaces the operand of read and write instructions.
- R6: A sequence ends at the first opcode-0 instruction, or after its eighth instruction.
- R7: Chip select goes low in the cycle after the trigger write. It returns high when the sequence ends and stays high for at least one clock. Busy is set from the trigger until chip select is back high.
- R8: The n-th received byte goes into byte lane n mod 4 of receive word n/4, which is read at offset 0x80+n/4. Bytes beyond 128 are dropped.
- R9: A write to offset 0x14 appends a 32-bit word to the transmit buffer, up to 64 bytes. Write instructions send its bytes lowest lane first.
- R10: A write to offset 0x00 with bit0 set empties the receive buffer. Bit1 set empties the transmit buffer.
- R11: A trigger written while the engine is busy is ignored.
- R12: Each bit takes two clocks, with `sck` low and then high. `mosi` is held steady while `sck` is high, and `miso` is taken at the end of the high clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 8 | Register word offset |
| cfgWdata | input | 32 | Register write data |
| cfgRdata | output | 32 | Register read data (combinational) |
| csN | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
A register write from software can land in the same cycle as an active sequence. The important case is a second trigger that arrives while chip select is still low. The bench starts a 64-clock-pulse sequence and then, mid-run, issues a trigger for a one-byte sequence. It judges the outcome at the pins: there must be exactly one chip-select low window, and the serial-clock pulse count must be that of the first sequence. The same overlap is checked against the busy flag, which must never rise in a cycle that was not an idle-time trigger.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam logic [5:0] OP_STOP  = 6'd0;
  localparam logic [5:0] OP_CMD   = 6'd1;
  localparam logic [5:0] OP_ADDR  = 6'd2;
  localparam logic [5:0] OP_DUMMY = 6'd3;
  localparam logic [5:0] OP_READ  = 6'd4;
  localparam logic [5:0] OP_WRITE = 6'd5;

  localparam logic [7:0] REG_CTRL = 8'h00;
  localparam logic [7:0] REG_KEY  = 8'h04;
  localparam logic [7:0] REG_LOCK = 8'h08;
  localparam logic [7:0] REG_ADDR = 8'h0C;
  localparam logic [7:0] REG_TRIG = 8'h10;
  localparam logic [7:0] REG_TXQ  = 8'h14;
  localparam logic [7:0] REG_STAT = 8'h18;

  typedef struct packed {
    logic [5:0] op;
    logic [1:0] pad;
    logic [7:0] arg;
  } instr_t;

  typedef struct packed {
    logic       ldCmd;
    logic       ldAddr;
    logic       addrWide;
    logic       ldTx;
    logic       shiftEn;
    logic       pushRx;
    logic [7:0] cmdByte;
  } strobe_t;
endpackage

// File: rtl/sfe_ctrl.sv
module sfe_ctrl
  import sfe_pkg::*;
#(
  parameter int NUM_SEQ = 8,
  localparam int SEQ_W = $clog2(NUM_SEQ),
  localparam int TBL_AW = SEQ_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigFire,
  input  logic [SEQ_W-1:0]  trigId,
  input  logic [7:0]        trigCnt,
  input  logic [31:0]       tblWord,
  output logic [TBL_AW-1:0] tblIdx,
  output strobe_t           stb,
  output logic              busy,
  output logic              csN,
  output logic              sck
);
  typedef enum logic [2:0] {S_IDLE, S_DECODE, S_SHIFT, S_NEXT, S_END} state_e;

  state_e           state, decNext;
  logic [SEQ_W-1:0] seqId;
  logic [2:0]       slot;
  logic [7:0]       remBits, remBytes, cntOvr, decBits, decBytes, len;
  logic [5:0]       curOp;
  logic             phase;
  instr_t           cur;

  assign tblIdx = {seqId, slot[2:1]};
  assign cur    = slot[0] ? tblWord[31:16] : tblWord[15:0];
  assign busy   = (state != S_IDLE);
  assign csN    = (state == S_IDLE) || (state == S_END);
  assign sck    = (state == S_SHIFT) && phase;

  always_comb begin
    stb      = '0;
    decNext  = S_SHIFT;
    decBits  = 8'd8;
    decBytes = 8'd1;
    len      = (cntOvr != 8'd0) ? cntOvr : cur.arg;
    if (state == S_DECODE) begin
      case (cur.op)
        OP_CMD: begin
          stb.ldCmd   = 1'b1;
          stb.cmdByte = cur.arg;
        end
        OP_ADDR: begin
          stb.ldAddr   = 1'b1;
          stb.addrWide = (cur.arg == 8'd32);
          decBits      = (cur.arg == 8'd32) ? 8'd32 : 8'd24;
        end
        OP_DUMMY:
          if (cur.arg == 8'd0) decNext = S_NEXT;
          else begin
            stb.ldCmd = 1'b1;
            decBits   = cur.arg;
          end
        OP_READ:
          if (len == 8'd0) decNext = S_NEXT;
          else begin
            stb.ldCmd = 1'b1;
            decBytes  = len;
          end
        OP_WRITE:
          if (len == 8'd0) decNext = S_NEXT;
          else begin
            stb.ldTx = 1'b1;
            decBytes = len;
          end
        default: decNext = S_END;
      endcase
    end
    if (state == S_SHIFT && phase) begin
      stb.shiftEn = 1'b1;
      if (remBits == 8'd1) begin
        if (curOp == OP_READ) stb.pushRx = 1'b1;
        if (curOp == OP_WRITE && remBytes != 8'd1) stb.ldTx = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      seqId    <= '0;
      slot     <= '0;
      remBits  <= '0;
      remBytes <= '0;
      cntOvr   <= '0;
      curOp    <= OP_STOP;
      phase    <= 1'b0;
    end else begin
      case (state)
        S_IDLE:
          if (trigFire) begin
            seqId  <= trigId;
            cntOvr <= trigCnt;
            slot   <= '0;
            state  <= S_DECODE;
          end
        S_DECODE: begin
          curOp    <= cur.op;
          phase    <= 1'b0;
          remBits  <= decBits;
          remBytes <= decBytes;
          state    <= decNext;
        end
        S_SHIFT: begin
          phase <= ~phase;
          if (phase) begin
            if (remBits == 8'd1) begin
              if (remBytes == 8'd1) state <= S_NEXT;
              else begin
                remBytes <= remBytes - 8'd1;
                remBits  <= 8'd8;
              end
            end else begin
              remBits <= remBits - 8'd1;
            end
          end
        end
        S_NEXT:
          if (slot == 3'd7) state <= S_END;
          else begin
            slot  <= slot + 3'd1;
            state <= S_DECODE;
          end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfe_datapath.sv
module sfe_datapath
  import sfe_pkg::*;
#(
  parameter int          NUM_SEQ  = 8,
  parameter int          RX_BYTES = 128,
  parameter int          TX_BYTES = 64,
  parameter logic [31:0] LOCK_KEY = 32'h5AF0_5AF0,
  localparam int SEQ_W = $clog2(NUM_SEQ),
  localparam int TBL_AW = SEQ_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [7:0]        cfgAddr,
  input  logic [31:0]       cfgWdata,
  output logic [31:0]       cfgRdata,
  input  logic              miso,
  output logic              mosi,
  input  logic              busy,
  input  strobe_t           stb,
  input  logic [TBL_AW-1:0] tblIdx,
  output logic [31:0]       tblWord,
  output logic              trigFire,
  output logic [SEQ_W-1:0]  trigId,
  output logic [7:0]        trigCnt
);
  localparam int TBL_WORDS = NUM_SEQ * 4;
  localparam int RX_WORDS  = RX_BYTES / 4;
  localparam int TX_WORDS  = TX_BYTES / 4;
  localparam int RXW_AW    = $clog2(RX_WORDS);
  localparam int TXW_AW    = $clog2(TX_WORDS);
  localparam int RXC_W     = $clog2(RX_BYTES + 1);
  localparam int TXC_W     = $clog2(TX_BYTES + 1);

  logic [31:0]      tbl   [TBL_WORDS];
  logic [31:0]      rxMem [RX_WORDS];
  logic [31:0]      txMem [TX_WORDS];
  logic             locked, keyArmed;
  logic [31:0]      flashAddr, shiftReg, stat;
  logic [7:0]       rxShift, rxByte, txByte;
  logic [RXC_W-1:0] rxFill;
  logic [TXC_W-1:0] txFill, txRd;
  logic             tblHit, rxHit, clrRx, clrTx;

  assign tblHit   = (cfgAddr[7:6] == 2'b01) && (cfgAddr[5:0] < 6'(TBL_WORDS));
  assign rxHit    = cfgAddr[7] && (cfgAddr[6:0] < 7'(RX_WORDS));
  assign clrRx    = cfgWe && (cfgAddr == REG_CTRL) && cfgWdata[0];
  assign clrTx    = cfgWe && (cfgAddr == REG_CTRL) && cfgWdata[1];
  assign trigFire = cfgWe && (cfgAddr == REG_TRIG) && !busy;
  assign trigId   = cfgWdata[8 +: SEQ_W];
  assign trigCnt  = cfgWdata[7:0];
  assign tblWord  = tbl[tblIdx];
  assign mosi     = shiftReg[31];
  assign rxByte   = {rxShift[6:0], miso};
  assign txByte   = (txRd < txFill) ? txMem[txRd[TXW_AW+1:2]][8*txRd[1:0] +: 8] : 8'h00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TBL_WORDS; i++) tbl[i] <= '0;
    end else if (cfgWe && tblHit && !locked) begin
      tbl[cfgAddr[TBL_AW-1:0]] <= cfgWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked    <= 1'b1;
      keyArmed  <= 1'b0;
      flashAddr <= '0;
    end else if (cfgWe) begin
      keyArmed <= (cfgAddr == REG_KEY) && (cfgWdata == LOCK_KEY);
      if (cfgAddr == REG_LOCK && keyArmed) begin
        if (cfgWdata[1:0] == 2'b10) locked <= 1'b0;
        else if (cfgWdata[1:0] == 2'b01) locked <= 1'b1;
      end
      if (cfgAddr == REG_ADDR) flashAddr <= cfgWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxShift  <= '0;
    end else begin
      if (stb.ldCmd)       shiftReg <= {stb.cmdByte, 24'h0};
      else if (stb.ldAddr) shiftReg <= stb.addrWide ? flashAddr : {flashAddr[23:0], 8'h0};
      else if (stb.ldTx)   shiftReg <= {txByte, 24'h0};
      else if (stb.shiftEn) shiftReg <= {shiftReg[30:0], 1'b0};
      if (stb.shiftEn) rxShift <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxFill <= '0;
    else if (clrRx) rxFill <= '0;
    else if (stb.pushRx && rxFill < RXC_W'(RX_BYTES)) rxFill <= rxFill + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!clrRx && stb.pushRx && rxFill < RXC_W'(RX_BYTES))
      rxMem[rxFill[RXW_AW+1:2]][8*rxFill[1:0] +: 8] <= rxByte;
    if (cfgWe && cfgAddr == REG_TXQ && !clrTx && txFill < TXC_W'(TX_BYTES))
      txMem[txFill[TXW_AW+1:2]] <= cfgWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFill <= '0;
      txRd   <= '0;
    end else if (clrTx) begin
      txFill <= '0;
      txRd   <= '0;
    end else begin
      if (cfgWe && cfgAddr == REG_TXQ && txFill < TXC_W'(TX_BYTES))
        txFill <= txFill + TXC_W'(4);
      if (stb.ldTx && txRd < TXC_W'(TX_BYTES)) txRd <= txRd + 1'b1;
    end
  end

  always_comb begin
    stat = {30'h0, locked, busy} | (32'(rxFill) << 8) | (32'(txFill) << 16);
    cfgRdata = '0;
    if (cfgAddr == REG_STAT)      cfgRdata = stat;
    else if (cfgAddr == REG_ADDR) cfgRdata = flashAddr;
    else if (tblHit)              cfgRdata = tbl[cfgAddr[TBL_AW-1:0]];
    else if (rxHit)               cfgRdata = rxMem[cfgAddr[RXW_AW-1:0]];
  end
endmodule

// File: rtl/seqflash_engine.sv
module seqflash_engine
  import sfe_pkg::*;
#(
  parameter int          NUM_SEQ  = 8,
  parameter int          RX_BYTES = 128,
  parameter int          TX_BYTES = 64,
  parameter logic [31:0] LOCK_KEY = 32'h5AF0_5AF0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [7:0]  cfgAddr,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata,
  output logic        csN,
  output logic        sck,
  output logic        mosi,
  input  logic        miso
);
  localparam int SEQ_W  = $clog2(NUM_SEQ);
  localparam int TBL_AW = SEQ_W + 2;

  strobe_t           stb;
  logic              busy, trigFire;
  logic [SEQ_W-1:0]  trigId;
  logic [7:0]        trigCnt;
  logic [TBL_AW-1:0] tblIdx;
  logic [31:0]       tblWord;

  sfe_datapath #(
    .NUM_SEQ(NUM_SEQ), .RX_BYTES(RX_BYTES), .TX_BYTES(TX_BYTES), .LOCK_KEY(LOCK_KEY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .miso(miso), .mosi(mosi), .busy(busy), .stb(stb),
    .tblIdx(tblIdx), .tblWord(tblWord), .trigFire(trigFire), .trigId(trigId),
    .trigCnt(trigCnt)
  );

  sfe_ctrl #(.NUM_SEQ(NUM_SEQ)) u_ctrl (
    .clk(clk), .rstN(rstN), .trigFire(trigFire), .trigId(trigId), .trigCnt(trigCnt),
    .tblWord(tblWord), .tblIdx(tblIdx), .stb(stb), .busy(busy), .csN(csN), .sck(sck)
  );
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sck,
  input logic mosi,
  input logic busy,
  input logic trigFire
);
  p_sck_in_frame_r12: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> !csN);
  p_mosi_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> $stable(mosi));
  p_cs_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |=> csN);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (csN && !sck));
  p_start_on_trigger_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(trigFire));
endmodule

bind seqflash_engine sfe_checker u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi),
  .busy(busy), .trigFire(trigFire)
);

// File: tb/seqflash_engine_tb.sv
module seqflash_engine_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgAddr = 8'h00;
  logic [31:0] cfgWdata = 32'h0;
  logic [31:0] cfgRdata;
  logic        csN, sck, mosi;
  logic        miso = 1'b0;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  localparam logic [31:0] KEY = 32'h5AF0_5AF0;
  localparam logic [127:0] MISO_PAT = 128'h00C2_2017_0011_2233_4455_6677_8899_AABB;
  // {seq, count, expected sck pulses, expected rx fill}
  localparam logic [31:0] VEC [7] = '{
    32'h00_00_20_03, 32'h00_02_18_02, 32'h01_00_48_04, 32'h01_01_30_01,
    32'h02_00_48_00, 32'h03_00_40_00, 32'h04_00_08_00
  };

  seqflash_engine u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .csN(csN), .sck(sck), .mosi(mosi), .miso(miso)
  );

  always #2 clk = ~clk;

  // flash model
  int pulses = 0;
  int csFalls = 0;
  logic [127:0] mosiLog = '0;
  always @(negedge csN) begin
    pulses = 0;
    csFalls++;
  end
  always @(posedge sck) begin
    miso = (pulses < 128) ? MISO_PAT[127 - pulses] : 1'b0;
    mosiLog = {mosiLog[126:0], mosi};
    pulses++;
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfgAddr = a;
    #1 d = cfgRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(8'h18, s);
      if (!s[0]) break;
    end
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 csN", {31'h0, csN}, 32'h1);
    chk("R1 sck", {31'h0, sck}, 32'h0);
    rd(8'h18, r); chk("R1 status", r, 32'h2);

    // R2 locked table ignores writes; unlock without key fails
    wr(8'h40, 32'h0000_1234);
    rd(8'h40, r); chk("R2 locked write ignored", r, 32'h0);
    wr(8'h08, 32'h2);
    rd(8'h18, r); chk("R2 unlock without key", {31'h0, r[1]}, 32'h1);
    wr(8'h04, KEY); wr(8'h08, 32'h2);
    rd(8'h18, r); chk("R2 unlocked", {31'h0, r[1]}, 32'h0);

    // program sequences (R3 layout)
    wr(8'h40, 32'h1003_049F);
    wr(8'h44, 32'h0818_040B); wr(8'h45, 32'h1004_0C08);
    wr(8'h48, 32'h0820_0402); wr(8'h49, 32'h0000_1404);
    wr(8'h4C, 32'h0412_0411); wr(8'h4D, 32'h0414_0413);
    wr(8'h4E, 32'h0416_0415); wr(8'h4F, 32'h0418_0417);
    wr(8'h50, 32'h0000_0406);
    rd(8'h45, r); chk("R3 table readback", r, 32'h1004_0C08);
    wr(8'h0C, 32'h1234_5678);

    // vector walk: R3 seq select, R5 count override, R6 termination
    foreach (VEC[i]) begin
      wr(8'h00, 32'h1);
      wr(8'h10, {16'h0, VEC[i][31:24], VEC[i][23:16]});
      waitIdle();
      chk($sformatf("R3/R5/R6 pulses vec%0d", i), pulses, {24'h0, VEC[i][15:8]});
      rd(8'h18, r);
      chk($sformatf("R5 rx fill vec%0d", i), {24'h0, r[15:8]}, {24'h0, VEC[i][7:0]});
    end

    // R4/R8/R12 identify read content and command bits
    wr(8'h00, 32'h1);
    wr(8'h10, 32'h0000_0000);
    waitIdle();
    chk("R12 command byte on mosi", {24'h0, mosiLog[31:24]}, 32'h9F);
    rd(8'h80, r); chk("R8 rx packing", {8'h0, r[23:0]}, 32'h0017_20C2);
    wr(8'h00, 32'h1);
    rd(8'h18, r); chk("R10 rx clear", {24'h0, r[15:8]}, 32'h0);

    // R4 24-bit address + dummy + read
    wr(8'h10, 32'h0000_0100);
    waitIdle();
    chk("R4 cmd", {24'h0, mosiLog[71:64]}, 32'h0B);
    chk("R4 addr24", {8'h0, mosiLog[63:40]}, 32'h0034_5678);
    rd(8'h80, r); chk("R8 read after dummy", r, 32'h4433_2211);

    // R9 write path with 32-bit address
    wr(8'h00, 32'h2);
    wr(8'h14, 32'hDDCC_BBAA);
    rd(8'h18, r); chk("R9 tx fill", {25'h0, r[22:16]}, 32'h4);
    wr(8'h10, 32'h0000_0200);
    waitIdle();
    chk("R4 addr32", mosiLog[63:32], 32'h1234_5678);
    chk("R9 tx bytes", mosiLog[31:0], 32'hAABB_CCDD);
    wr(8'h14, 32'h1);
    wr(8'h00, 32'h2);
    rd(8'h18, r); chk("R10 tx clear", {25'h0, r[22:16]}, 32'h0);

    // R8 overflow bound
    wr(8'h00, 32'h1);
    wr(8'h10, 32'h0000_00C8);
    waitIdle();
    rd(8'h18, r); chk("R8 rx saturates at 128", {24'h0, r[15:8]}, 32'd128);

    // R7 / R11: trigger during busy ignored
    csFalls = 0;
    wr(8'h10, 32'h0000_0300);
    chk("R7 csN low after trigger", {31'h0, csN}, 32'h0);
    rd(8'h18, r); chk("R7 busy set", {31'h0, r[0]}, 32'h1);
    repeat (10) @(negedge clk);
    wr(8'h10, 32'h0000_0400);
    waitIdle();
    chk("R11 pulses of first seq only", pulses, 32'd64);
    chk("R11 single cs window", csFalls, 32'd1);
    chk("R7 csN high at idle", {31'h0, csN}, 32'h1);

    // R2 relock
    wr(8'h04, KEY); wr(8'h08, 32'h1);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, r); chk("R2 relocked write ignored", r, 32'h1003_049F);
    rd(8'h18, r); chk("R2 locked flag", {31'h0, r[1]}, 32'h1);

    done = 1'b1;
    summary();
  end
endmodule